// File: doc/BRIEF.md
# Vector Shift-Left-and-Insert Unit

This block is a vector datapath that shifts every element of a source vector left by a constant amount and writes the result over the matching element of a destination vector. The bits that the shift leaves empty at the bottom of each element are not zero-filled. They keep the value that the destination element already held. This lets software assemble bit fields from two registers with one operation.

The element width and the shift amount are both carried in one 7-bit immediate. It arrives as a 2-bit upper size field, a 2-bit lower size field and a 3-bit low immediate. An all-zero size code is an illegal encoding and is flagged. Every lane of the vector is processed, because there is no predicate. The vector length is a parameter that must be a multiple of 128 bits. An optional output register, loaded when `in_valid` is high, gives one cycle of latency and a matching `out_valid`.

Top module: `vec_sli_unit`

## Requirements
- R1: The 4-bit size code is {sz_hi, sz_lo}. A size code of 0000 sets `out_undef`; any other code clears it.
- R2: The element width comes from the size code: 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R3: The shift amount is the unsigned 7-bit value {sz_hi, sz_lo, imm_lo} minus the element width. For a legal code it always lies between 0 and width-1.
- R4: In each element, result bits below the shift amount equal the old destination bits. Result bit k at or above the shift amount equals source bit k-shift of the same element. Source bits shifted past the element top are lost.
- R5: All VLEN/width lanes are computed, with no lane masking.
- R6: With a legal code and a shift of 0, the result equals the source vector exactly.
- R7: For an illegal code, `out_vec` equals the destination input unchanged.
- R8: With REG_OUT=1, the result and flag are captured on a clock edge where `in_valid` is high, and `out_valid` is high for the following cycle. While `in_valid` is low, `out_vec` and `out_undef` hold their values.
- R9: While reset is asserted, `out_valid`, `out_undef` and `out_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and immediate are valid this cycle |
| src_vec | input | VLEN | Vector whose elements are shifted |
| dst_vec | input | VLEN | Current destination vector, merged into the low bits |
| sz_hi | input | 2 | Upper half of the size code |
| sz_lo | input | 2 | Lower half of the size code |
| imm_lo | input | 3 | Low immediate bits |
| out_valid | output | 1 | Result is valid |
| out_vec | output | VLEN | New destination vector |
| out_undef | output | 1 | The size code was the reserved all-zero value |

## Verification
With the default output register, every result (`out_vec`, `out_undef` and `out_valid`) is due exactly one clock edge after the edge that samples `in_valid` high. The bench changes inputs on the falling edge and pulses `in_valid` for one cycle. It compares all outputs at the next falling edge, which lies after exactly one register stage. Hold behaviour is checked one falling edge later, after new operands have been applied with `in_valid` low, so that a design that ignores the enable would already have changed its output.

// File: rtl/sli_pkg.sv
`timescale 1ns/1ps
package sli_pkg;

  localparam int NUM_WIDTHS = 4;
  localparam int SHIFT_W    = 6;

  typedef struct packed {
    logic                  undef;
    logic [NUM_WIDTHS-1:0] sel;    // one-hot: 8,16,32,64
    logic [SHIFT_W-1:0]    shift;
  } sli_dec_t;

  // Element width in bits for a one-hot select index.
  function automatic logic [6:0] width_of_idx(input int idx);
    return 7'(8 << idx);
  endfunction

  // Decode the combined size+immediate field.
  function automatic sli_dec_t decode_field(input logic [3:0] tsz, input logic [2:0] imm);
    sli_dec_t   d;
    logic [6:0] code;
    logic [6:0] wid;
    code    = {tsz, imm};
    d.undef = 1'b0;
    d.sel   = '0;
    casez (tsz)
      4'b1???: d.sel = 4'b1000;
      4'b01??: d.sel = 4'b0100;
      4'b001?: d.sel = 4'b0010;
      4'b0001: d.sel = 4'b0001;
      default: d.undef = 1'b1;
    endcase
    wid = 7'd0;
    for (int i = 0; i < NUM_WIDTHS; i++)
      if (d.sel[i]) wid = width_of_idx(i);
    d.shift = d.undef ? '0 : SHIFT_W'(code - wid);
    return d;
  endfunction

endpackage

// File: rtl/sli_decode.sv
`timescale 1ns/1ps
module sli_decode
  import sli_pkg::*;
(
  input  logic [1:0]            sz_hi,
  input  logic [1:0]            sz_lo,
  input  logic [2:0]            imm_lo,
  output logic                  undef,
  output logic [NUM_WIDTHS-1:0] sel,
  output logic [SHIFT_W-1:0]    shift
);
  sli_dec_t dec;

  always_comb begin
    dec   = decode_field({sz_hi, sz_lo}, imm_lo);
    undef = dec.undef;
    sel   = dec.sel;
    shift = dec.shift;
  end
endmodule

// File: rtl/sli_lane.sv
`timescale 1ns/1ps
module sli_lane #(
  parameter int W       = 8,
  parameter int SHIFT_W = 6
) (
  input  logic [W-1:0]       old_d,
  input  logic [W-1:0]       src,
  input  logic [SHIFT_W-1:0] shift,
  output logic [W-1:0]       res
);
  logic [W-1:0] keep_mask;

  always_comb begin
    keep_mask = {W{1'b1}} << shift;
    res       = (old_d & ~keep_mask) | (src << shift);
  end
endmodule

// File: rtl/sli_lane_array.sv
`timescale 1ns/1ps
module sli_lane_array
  import sli_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic [VLEN-1:0]       src_vec,
  input  logic [VLEN-1:0]       dst_vec,
  input  logic [NUM_WIDTHS-1:0] sel,
  input  logic [SHIFT_W-1:0]    shift,
  output logic [VLEN-1:0]       merged
);
  logic [VLEN-1:0] cand [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int W     = 8 << g;
    localparam int LANES = VLEN / W;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      sli_lane #(.W(W), .SHIFT_W(SHIFT_W)) u_lane (
        .old_d (dst_vec[l*W +: W]),
        .src   (src_vec[l*W +: W]),
        .shift (shift),
        .res   (cand[g][l*W +: W])
      );
    end
  end

  // No width selected (reserved code) leaves the destination untouched.
  always_comb begin
    merged = dst_vec;
    for (int g = 0; g < NUM_WIDTHS; g++)
      if (sel[g]) merged = cand[g];
  end
endmodule

// File: rtl/sli_out_stage.sv
`timescale 1ns/1ps
module sli_out_stage #(
  parameter int VLEN    = 256,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VLEN-1:0] d_vec,
  input  logic            d_undef,
  output logic            q_valid,
  output logic [VLEN-1:0] q_vec,
  output logic            q_undef
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_vec   <= '0;
        q_undef <= 1'b0;
      end else begin
        q_valid <= in_valid;
        if (in_valid) begin
          q_vec   <= d_vec;
          q_undef <= d_undef;
        end
      end
    end
  end else begin : g_comb
    assign q_valid = in_valid;
    assign q_vec   = d_vec;
    assign q_undef = d_undef;
  end
endmodule

// File: rtl/vec_sli_unit.sv
`timescale 1ns/1ps
module vec_sli_unit
  import sli_pkg::*;
#(
  parameter int VLEN    = 256,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] dst_vec,
  input  logic [1:0]      sz_hi,
  input  logic [1:0]      sz_lo,
  input  logic [2:0]      imm_lo,
  output logic            out_valid,
  output logic [VLEN-1:0] out_vec,
  output logic            out_undef
);
  localparam int CHUNKS = VLEN / 128;

  initial begin
    if (CHUNKS * 128 != VLEN || VLEN == 0)
      $error("VLEN must be a non-zero multiple of 128");
  end

  // Named internal events, observed by the bound checker.
  logic                  dec_undef;
  logic [NUM_WIDTHS-1:0] dec_sel;
  logic [SHIFT_W-1:0]    dec_shift;
  logic [VLEN-1:0]       merged;

  sli_decode u_dec (
    .sz_hi  (sz_hi),
    .sz_lo  (sz_lo),
    .imm_lo (imm_lo),
    .undef  (dec_undef),
    .sel    (dec_sel),
    .shift  (dec_shift)
  );

  sli_lane_array #(.VLEN(VLEN)) u_lanes (
    .src_vec (src_vec),
    .dst_vec (dst_vec),
    .sel     (dec_sel),
    .shift   (dec_shift),
    .merged  (merged)
  );

  sli_out_stage #(.VLEN(VLEN), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d_vec    (merged),
    .d_undef  (dec_undef),
    .q_valid  (out_valid),
    .q_vec    (out_vec),
    .q_undef  (out_undef)
  );
endmodule

// File: rtl/vec_sli_checker.sv
`timescale 1ns/1ps
module vec_sli_checker
  import sli_pkg::*;
#(
  parameter int VLEN    = 256,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [VLEN-1:0]       src_vec,
  input logic [VLEN-1:0]       dst_vec,
  input logic                  dec_undef,
  input logic [NUM_WIDTHS-1:0] dec_sel,
  input logic [SHIFT_W-1:0]    dec_shift,
  input logic [VLEN-1:0]       merged,
  input logic                  out_valid,
  input logic [VLEN-1:0]       out_vec,
  input logic                  out_undef
);
  logic [6:0] sel_width;
  always_comb begin
    sel_width = 7'd0;
    for (int i = 0; i < NUM_WIDTHS; i++)
      if (dec_sel[i]) sel_width = width_of_idx(i);
  end

  assert_sel_matches_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_sel) && ((dec_sel == '0) == dec_undef));

  assert_shift_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_undef |-> ({1'b0, dec_shift} < sel_width));

  assert_undef_keeps_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_undef |-> (merged == dst_vec));

  assert_zero_shift_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_undef && dec_shift == '0) |-> (merged == src_vec));

  if (REG_OUT) begin : g_seq
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_vec) && $stable(out_undef) && !out_valid));

    assert_flag_captured_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_undef == $past(dec_undef)));
  end
endmodule

bind vec_sli_unit vec_sli_checker #(.VLEN(VLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .src_vec   (src_vec),
  .dst_vec   (dst_vec),
  .dec_undef (dec_undef),
  .dec_sel   (dec_sel),
  .dec_shift (dec_shift),
  .merged    (merged),
  .out_valid (out_valid),
  .out_vec   (out_vec),
  .out_undef (out_undef)
);

// File: tb/vec_sli_unit_bench.sv
`timescale 1ns/1ps
module vec_sli_unit_bench;
  localparam int VLEN = 256;
  localparam int NV   = 14;

  // Entry: {code7[20:14], width[13:7], shift[6:1], undef[0]}
  localparam logic [20:0] TBL [NV] = '{
    {7'b0001_000, 7'd8,  6'd0,  1'b0},
    {7'b0001_111, 7'd8,  6'd7,  1'b0},
    {7'b0001_011, 7'd8,  6'd3,  1'b0},
    {7'b0010_000, 7'd16, 6'd0,  1'b0},
    {7'b0011_111, 7'd16, 6'd15, 1'b0},
    {7'b0010_101, 7'd16, 6'd5,  1'b0},
    {7'b0100_000, 7'd32, 6'd0,  1'b0},
    {7'b0111_111, 7'd32, 6'd31, 1'b0},
    {7'b0101_010, 7'd32, 6'd10, 1'b0},
    {7'b1000_000, 7'd64, 6'd0,  1'b0},
    {7'b1111_111, 7'd64, 6'd63, 1'b0},
    {7'b1010_001, 7'd64, 6'd17, 1'b0},
    {7'b0000_101, 7'd0,  6'd0,  1'b1},
    {7'b0000_000, 7'd0,  6'd0,  1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] dst_vec = '0;
  logic [1:0]      sz_hi = '0;
  logic [1:0]      sz_lo = '0;
  logic [2:0]      imm_lo = '0;
  logic            out_valid;
  logic [VLEN-1:0] out_vec;
  logic            out_undef;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vec_sli_unit #(.VLEN(VLEN), .REG_OUT(1'b1)) u_vec_sli_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .dst_vec(dst_vec),
    .sz_hi(sz_hi), .sz_lo(sz_lo), .imm_lo(imm_lo),
    .out_valid(out_valid), .out_vec(out_vec), .out_undef(out_undef)
  );

  // Bit-wise model: each result bit comes from dst below the shift, else src.
  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] s, input logic [VLEN-1:0] d,
                                            input int w, input int sh);
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLEN; i++) begin
      if ((i % w) < sh) r[i] = d[i];
      else              r[i] = s[i - sh];
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // One-cycle pulse; the result is due after one register stage.
  task automatic issue(input logic [6:0] code, input logic [VLEN-1:0] s, input logic [VLEN-1:0] d);
    @(negedge clk);
    {sz_hi, sz_lo, imm_lo} = code;
    src_vec = s; dst_vec = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [VLEN-1:0] s, d, exp, held;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk_bit("R9 valid in reset", out_valid, 1'b0);
    chk_bit("R9 undef in reset", out_undef, 1'b0);
    chk_vec("R9 vec in reset", out_vec, '0);
    rst_n = 1'b1;

    for (int e = 0; e < NV; e++) begin
      for (int rnd = 0; rnd < 3; rnd++) begin
        logic [6:0] code; int w, sh; logic und;
        code = TBL[e][20:14]; w = int'(TBL[e][13:7]); sh = int'(TBL[e][6:1]); und = TBL[e][0];
        if (rnd == 1) begin s = '1; d = '0; end
        else begin s = rand_vec(); d = rand_vec(); end
        issue(code, s, d);
        exp = und ? d : model(s, d, w, sh);
        chk_bit("R8 out_valid after pulse", out_valid, 1'b1);
        chk_bit("R1 undefined flag", out_undef, und);
        // R2 R3 R4 R5: every lane of every width against the model
        chk_vec(und ? "R7 reserved keeps dst" : "R4 lane merge", out_vec, exp);
        if (!und && sh == 0) chk_vec("R6 zero shift copies src", out_vec, s);
      end
    end

    // R8: inputs change while in_valid is low; outputs must hold
    issue(7'b0001_100, rand_vec(), rand_vec());
    held = out_vec;
    @(negedge clk);
    sz_hi = 2'b11; src_vec = rand_vec(); dst_vec = ~dst_vec;
    @(negedge clk);
    chk_bit("R8 out_valid low when idle", out_valid, 1'b0);
    chk_vec("R8 out_vec holds", out_vec, held);
    chk_bit("R8 out_undef holds", out_undef, 1'b0);

    // R4: byte lanes, shift 4: (AB<<4)|(CD low nibble) = BD
    issue(7'b0001_100, {32{8'hAB}}, {32{8'hCD}});
    chk_vec("R4 byte shift 4", out_vec, {32{8'hBD}});

    // R4: 64-bit lanes, shift 63: only top bit from src, rest from dst
    issue(7'b1111_111, '1, '0);
    chk_vec("R4 dword shift 63", out_vec, {4{64'h8000_0000_0000_0000}});

    // R3: 16-bit code 0011_000 gives shift 8
    issue(7'b0011_000, {16{16'h00FF}}, {16{16'h1234}});
    chk_vec("R3 half shift 8", out_vec, {16{16'hFF34}});

    // R7: reserved code keeps dst even with all-ones source
    issue(7'b0000_111, '1, {8{32'h5A5A_0F0F}});
    chk_vec("R7 reserved passthrough", out_vec, {8{32'h5A5A_0F0F}});
    chk_bit("R1 reserved flag set", out_undef, 1'b1);

    // R9: reset clears a live result
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_vec("R9 vec cleared by reset", out_vec, '0);
    chk_bit("R9 undef cleared by reset", out_undef, 1'b0);

    finished = 1'b1;
    summary();
  end
endmodule